// File: doc/BRIEF.md
# Hash Accelerator Control Register File

This block is the software-facing register set of a hash and MAC engine. A 32-bit register bus with a write strobe, a byte address, write data and combinational read data reaches a control word, a status word, four operation parameters and a write-only key selector. Toward the engine the block drives a one-cycle start pulse and a one-cycle stop pulse. It also drives the decoded hash algorithm, the HMAC and DMA option bits, and the parameter values. From the engine it takes done, DMA-busy, DMA-error, key-error and data-request indications.

Every operation parameter has a live copy and a shadow copy. Software reads and writes the live copy. The engine sees only the shadow copy, which is loaded at the instant a start command is accepted. The algorithm and option bits follow the same rule. As a result, software can prepare the next run while the current one proceeds undisturbed.

Byte map used below: control 0x00, status 0x04, source address 0x08, byte count 0x0C, key byte count 0x10, feedback address 0x14, key selector 0x18. Any other address reads 0.

Top module: `hash_csr_top`

## Requirements
- R1: Writing 1 to control bit 0 while idle raises `eng_start` for exactly one cycle after the write and sets busy (status bit 0). Control bit 0 always reads 0.
- R2: Writing 1 to control bit 1 raises `eng_stop` for one cycle after the write and clears busy. Control bit 1 always reads 0. When bits 0 and 1 are written together, the stop wins and no start pulse is produced.
- R3: At an accepted start, control bits 10:8, together with bit 13, select `eng_algo`. Bit 13 set gives SM3 (5) and overrides the mode bits. Otherwise 0xx gives SHA-1 (0), 100 gives SHA-256 (2), 101 gives SHA-224 (1), 110 gives SHA-512 (4) and 111 gives SHA-384 (3). Bit 11 is latched as `eng_hmac`.
- R4: While busy, control writes are stored and read back through mask 0x2F80, but `eng_algo` and `eng_hmac` keep their latched values. A start written while busy, in a cycle without `eng_done`, is ignored.
- R5: `eng_done` clears busy. If `eng_done` and an accepted start write fall in the same cycle, the start wins: busy stays 1, a new start pulse is produced and new values are latched.
- R6: Status reads as busy at bit 0, DMA busy at bit 1, DMA error at bit 8, key error at bit 9 and data request at bit 16, with all other bits 0. Writes to status have no effect.
- R7: The source address, byte count, key byte count and feedback address are readable and writable at any time. Their engine-side outputs change only when a start is accepted.
- R8: Bits 1:0 of the source address and of the feedback address always read as 0 and are always driven as 0.
- R9: A write to the key selector drives bits 4:0 to `key_num`, bit 5 to `key_from_store` (1 = key store) and bits 7:6 to `key_origin` (00 = SRAM, 10 = OTP). Reads of the key selector return 0.
- R10: `eng_key_err` during a busy HMAC run clears busy and produces a one-cycle `eng_stop`. It does neither during a plain hash run.
- R11: Synchronous active-low reset sets every register, pulse and shadow to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| eng_done | input | 1 | Engine finished the run |
| eng_dma_busy | input | 1 | DMA mover active |
| eng_dma_err | input | 1 | DMA access error |
| eng_key_err | input | 1 | Key store access error |
| eng_data_req | input | 1 | Engine requests input data |
| eng_start | output | 1 | One-cycle start pulse |
| eng_stop | output | 1 | One-cycle stop pulse |
| eng_algo | output | 3 | Latched algorithm code |
| eng_hmac | output | 1 | Latched HMAC select |
| eng_dma_en | output | 1 | Latched DMA enable (control bit 7) |
| eng_src_addr | output | 32 | Shadow source address |
| eng_byte_cnt | output | 32 | Shadow byte count |
| eng_key_cnt | output | 32 | Shadow key byte count |
| eng_fb_addr | output | 32 | Shadow feedback address |
| key_num | output | 5 | Selected key number |
| key_from_store | output | 1 | Key taken from key store |
| key_origin | output | 2 | Key store origin |

## Verification
The bench builds the block with its default parameters: an 8-bit byte address, 32-bit data and four parameter registers, two of them word-aligned. This keeps the whole map in reach, including unmapped addresses and both aligned and unaligned parameters. Runs are driven through every algorithm code, including the SM3 override and the don't-care SHA-1 pattern. The bench also covers writes made while busy, a done that coincides with a restart, stop and start written together, and key errors in HMAC and plain runs.

// File: rtl/hash_csr_pkg.sv
// Package: shared constants and types for the hash control register file.
// Assumes byte addressing on a 32-bit bus; offsets below are word indices.
package hash_csr_pkg;

    typedef enum logic [2:0] {
        ALG_SHA1   = 3'd0,
        ALG_SHA224 = 3'd1,
        ALG_SHA256 = 3'd2,
        ALG_SHA384 = 3'd3,
        ALG_SHA512 = 3'd4,
        ALG_SM3    = 3'd5
    } algo_t;

    // Word indices of the map
    localparam int unsigned WI_CTRL   = 0;
    localparam int unsigned WI_STAT   = 1;
    localparam int unsigned WI_PARAM0 = 2;
    localparam int unsigned WI_KEYSEL = 6;

    // Control bit positions
    localparam int unsigned CB_START = 0;
    localparam int unsigned CB_STOP  = 1;
    localparam int unsigned CB_DMA   = 7;
    localparam int unsigned CB_MODE  = 8;
    localparam int unsigned CB_HMAC  = 11;
    localparam int unsigned CB_SM3   = 13;

    // Control bits that are stored and read back
    localparam logic [31:0] CTRL_KEEP = 32'h0000_2F80;

    // Map the mode field and SM3 select to an algorithm code
    function automatic algo_t decode_algo(input logic sm3, input logic [2:0] mode);
        algo_t a;
        if (sm3)             a = ALG_SM3;
        else if (!mode[2])   a = ALG_SHA1;
        else begin
            case (mode[1:0])
                2'b00:   a = ALG_SHA256;
                2'b01:   a = ALG_SHA224;
                2'b10:   a = ALG_SHA512;
                default: a = ALG_SHA384;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/hash_csr_ctrl.sv
// Control word, busy tracking and engine command pulses.
// Assumes ctrl_we is already qualified by the address decode; start is
// accepted only when idle or when the engine reports done in the same cycle.
module hash_csr_ctrl
    import hash_csr_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic [DW-1:0] wdata,
    input  logic          eng_done,
    input  logic          eng_key_err,
    output logic [DW-1:0] ctrl_rd,
    output logic          busy,
    output logic          start_acc,
    output logic          eng_start,
    output logic          eng_stop,
    output algo_t         eng_algo,
    output logic          eng_hmac,
    output logic          eng_dma_en
);

    logic [DW-1:0] ctrl_q;
    logic          stop_req;
    logic          key_abort;

    // Decode the command bits of a control write
    always_comb begin
        stop_req  = ctrl_we && wdata[CB_STOP];
        start_acc = ctrl_we && wdata[CB_START] && !wdata[CB_STOP] && (!busy || eng_done);
        key_abort = busy && eng_hmac && eng_key_err && !start_acc;
    end

    // Readable copy of the control word, stored regardless of busy
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= wdata & DW'(CTRL_KEEP);
    end

    assign ctrl_rd = ctrl_q;

    // Busy flag: set by an accepted start, cleared by stop, done or key abort
    always_ff @(posedge clk) begin
        if (!rst_n)                                busy <= 1'b0;
        else if (start_acc)                        busy <= 1'b1;
        else if (stop_req || eng_done || key_abort) busy <= 1'b0;
    end

    // One-cycle command pulses toward the engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_start <= 1'b0;
            eng_stop  <= 1'b0;
        end else begin
            eng_start <= start_acc;
            eng_stop  <= stop_req || key_abort;
        end
    end

    // Algorithm and options latched only when a start is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_algo   <= ALG_SHA1;
            eng_hmac   <= 1'b0;
            eng_dma_en <= 1'b0;
        end else if (start_acc) begin
            eng_algo   <= decode_algo(wdata[CB_SM3], wdata[CB_MODE +: 3]);
            eng_hmac   <= wdata[CB_HMAC];
            eng_dma_en <= wdata[CB_DMA];
        end
    end

    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> busy);

    p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_stop |-> !busy);

    p_algo_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_start) |-> ($stable(eng_algo) && $stable(eng_hmac)));

    p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done && !start_acc) |=> !busy);

    p_key_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_hmac && eng_key_err && !start_acc) |=> (eng_stop && !busy));

endmodule

// File: rtl/hash_csr_params.sv
// Bank of operation parameters, each with a live and a shadow copy.
// Assumes wr_en is one-hot or zero; ALIGN_MASK bit i forces bits 1:0 of
// parameter i to zero. Shadows load from the live copies on latch.
module hash_csr_params #(
    parameter int unsigned         NPARAM     = 4,
    parameter int unsigned         DW         = 32,
    parameter logic [NPARAM-1:0]   ALIGN_MASK = 4'b1001
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPARAM-1:0]            wr_en,
    input  logic [DW-1:0]                wdata,
    input  logic                         latch,
    output logic [NPARAM-1:0][DW-1:0]    live,
    output logic [NPARAM-1:0][DW-1:0]    shadow
);

    for (genvar i = 0; i < NPARAM; i++) begin : g_par
        localparam logic [DW-1:0] KEEP = ALIGN_MASK[i] ? ~DW'(3) : '1;

        // Live copy, written from the bus at any time
        always_ff @(posedge clk) begin
            if (!rst_n)        live[i] <= '0;
            else if (wr_en[i]) live[i] <= wdata & KEEP;
        end

        // Shadow copy, loaded only when a run starts
        always_ff @(posedge clk) begin
            if (!rst_n)     shadow[i] <= '0;
            else if (latch) shadow[i] <= live[i];
        end

        if (ALIGN_MASK[i]) begin : g_al
            p_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (live[i][1:0] == 2'b00) && (shadow[i][1:0] == 2'b00));
        end

        p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !latch |=> $stable(shadow[i]));
    end

endmodule

// File: rtl/hash_csr_keysel.sv
// Write-only key selector: number, source and key-store origin.
// Assumes key_we is qualified by the address decode; nothing is read back.
module hash_csr_keysel #(
    parameter int unsigned NUM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_we,
    input  logic [NUM_W+2:0] wdata,
    output logic [NUM_W-1:0] key_num,
    output logic             key_from_store,
    output logic [1:0]       key_origin
);

    // Capture the selector fields on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_num        <= '0;
            key_from_store <= 1'b0;
            key_origin     <= 2'b00;
        end else if (key_we) begin
            key_num        <= wdata[NUM_W-1:0];
            key_from_store <= wdata[NUM_W];
            key_origin     <= wdata[NUM_W+2:NUM_W+1];
        end
    end

    p_keysel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !key_we |=> ($stable(key_num) && $stable(key_origin) && $stable(key_from_store)));

endmodule

// File: rtl/hash_csr_top.sv
// Register file of a hash/MAC engine: address decode, read mux and the
// control, parameter and key-select sub-blocks. Reads are combinational.
module hash_csr_top
    import hash_csr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DW     = 32,
    parameter int unsigned NPARAM = 4,
    parameter int unsigned KNUM_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              eng_done,
    input  logic              eng_dma_busy,
    input  logic              eng_dma_err,
    input  logic              eng_key_err,
    input  logic              eng_data_req,
    output logic              eng_start,
    output logic              eng_stop,
    output logic [2:0]        eng_algo,
    output logic              eng_hmac,
    output logic              eng_dma_en,
    output logic [DW-1:0]     eng_src_addr,
    output logic [DW-1:0]     eng_byte_cnt,
    output logic [DW-1:0]     eng_key_cnt,
    output logic [DW-1:0]     eng_fb_addr,
    output logic [KNUM_W-1:0] key_num,
    output logic              key_from_store,
    output logic [1:0]        key_origin
);

    localparam logic [ADDR_W-1:0] W_CTRL   = ADDR_W'(WI_CTRL);
    localparam logic [ADDR_W-1:0] W_STAT   = ADDR_W'(WI_STAT);
    localparam logic [ADDR_W-1:0] W_PARAM0 = ADDR_W'(WI_PARAM0);
    localparam logic [ADDR_W-1:0] W_KEYSEL = ADDR_W'(WI_KEYSEL);

    logic [ADDR_W-1:0]             word;
    logic [DW-1:0]                 ctrl_rd;
    logic [DW-1:0]                 stat_rd;
    logic                          busy;
    logic                          start_acc;
    algo_t                         algo_q;
    logic [NPARAM-1:0]             par_we;
    logic [NPARAM-1:0][DW-1:0]     par_live;
    logic [NPARAM-1:0][DW-1:0]     par_shadow;

    assign word = bus_addr >> 2;

    for (genvar i = 0; i < NPARAM; i++) begin : g_pwe
        assign par_we[i] = bus_we && (word == W_PARAM0 + ADDR_W'(i));
    end

    hash_csr_ctrl #(.DW(DW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (bus_we && (word == W_CTRL)),
        .wdata      (bus_wdata),
        .eng_done   (eng_done),
        .eng_key_err(eng_key_err),
        .ctrl_rd    (ctrl_rd),
        .busy       (busy),
        .start_acc  (start_acc),
        .eng_start  (eng_start),
        .eng_stop   (eng_stop),
        .eng_algo   (algo_q),
        .eng_hmac   (eng_hmac),
        .eng_dma_en (eng_dma_en)
    );

    hash_csr_params #(.NPARAM(NPARAM), .DW(DW)) u_params (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (par_we),
        .wdata (bus_wdata),
        .latch (start_acc),
        .live  (par_live),
        .shadow(par_shadow)
    );

    hash_csr_keysel #(.NUM_W(KNUM_W)) u_keysel (
        .clk           (clk),
        .rst_n         (rst_n),
        .key_we        (bus_we && (word == W_KEYSEL)),
        .wdata         (bus_wdata[KNUM_W+2:0]),
        .key_num       (key_num),
        .key_from_store(key_from_store),
        .key_origin    (key_origin)
    );

    assign eng_algo     = algo_q;
    assign eng_src_addr = par_shadow[0];
    assign eng_byte_cnt = par_shadow[1];
    assign eng_key_cnt  = par_shadow[2];
    assign eng_fb_addr  = par_shadow[3];

    // Assemble the status word from busy and the engine flags
    always_comb begin
        stat_rd     = '0;
        stat_rd[0]  = busy;
        stat_rd[1]  = eng_dma_busy;
        stat_rd[8]  = eng_dma_err;
        stat_rd[9]  = eng_key_err;
        stat_rd[16] = eng_data_req;
    end

    // Read mux over the map; key selector and holes read as zero
    always_comb begin
        bus_rdata = '0;
        if (word == W_CTRL)      bus_rdata = ctrl_rd;
        else if (word == W_STAT) bus_rdata = stat_rd;
        else begin
            for (int i = 0; i < NPARAM; i++) begin
                if (word == W_PARAM0 + ADDR_W'(i)) bus_rdata = par_live[i];
            end
        end
    end

    p_start_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (eng_src_addr == $past(par_live[0])));

endmodule

// File: tb/test_hash_csr_top.sv
// Scoreboard bench: driver tasks push expected items, a monitor at the
// falling edge pops and compares them against the observed outputs.
module test_hash_csr_top;

    localparam int K_RD = 0, K_START = 1, K_STOP = 2, K_ALGO = 3, K_HMAC = 4,
                   K_SRC = 5, K_CNT = 6, K_KCNT = 7, K_FB = 8, K_KEY = 9;
    localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_SRC = 8'h08,
                           A_CNT = 8'h0C, A_KCNT = 8'h10, A_FB = 8'h14, A_KEY = 8'h18;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_done = 1'b0, eng_dma_busy = 1'b0, eng_dma_err = 1'b0;
    logic        eng_key_err = 1'b0, eng_data_req = 1'b0;
    logic        eng_start, eng_stop, eng_hmac, eng_dma_en, key_from_store;
    logic [2:0]  eng_algo;
    logic [31:0] eng_src_addr, eng_byte_cnt, eng_key_cnt, eng_fb_addr;
    logic [4:0]  key_num;
    logic [1:0]  key_origin;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done_flag = 1'b0;
    item_t q[$];

    always #2 clk = ~clk;

    hash_csr_top i_hash_csr_top (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_done(eng_done),
        .eng_dma_busy(eng_dma_busy), .eng_dma_err(eng_dma_err),
        .eng_key_err(eng_key_err), .eng_data_req(eng_data_req),
        .eng_start(eng_start), .eng_stop(eng_stop), .eng_algo(eng_algo),
        .eng_hmac(eng_hmac), .eng_dma_en(eng_dma_en), .eng_src_addr(eng_src_addr),
        .eng_byte_cnt(eng_byte_cnt), .eng_key_cnt(eng_key_cnt),
        .eng_fb_addr(eng_fb_addr), .key_num(key_num),
        .key_from_store(key_from_store), .key_origin(key_origin)
    );

    function automatic logic [31:0] observe(input int kind);
        case (kind)
            K_RD:    return bus_rdata;
            K_START: return {31'b0, eng_start};
            K_STOP:  return {31'b0, eng_stop};
            K_ALGO:  return {29'b0, eng_algo};
            K_HMAC:  return {31'b0, eng_hmac};
            K_SRC:   return eng_src_addr;
            K_CNT:   return eng_byte_cnt;
            K_KCNT:  return eng_key_cnt;
            K_FB:    return eng_fb_addr;
            default: return {24'b0, key_origin, key_from_store, key_num};
        endcase
    endfunction

    // Monitor: compare every queued expectation away from the rising edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = observe(it.kind);
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic chk(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        chk(K_RD, exp, tag);
        step();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(); step();
        // R11: state while reset is held
        chk(K_START, 0, "R11 start"); chk(K_STOP, 0, "R11 stop");
        chk(K_ALGO, 0, "R11 algo"); chk(K_SRC, 0, "R11 src"); chk(K_KEY, 0, "R11 key");
        rd(A_CTRL, 0, "R11 ctrl");
        rd(A_STAT, 0, "R11 status");
        rst_n = 1'b1;
        step();

        // R8 / R7: parameter programming before any run
        wr(A_SRC, 32'h1000_0007);  rd(A_SRC, 32'h1000_0004, "R8 src low bits");
        wr(A_CNT, 32'd64);
        wr(A_KCNT, 32'd32);
        wr(A_FB, 32'h0000_2003);   rd(A_FB, 32'h0000_2000, "R8 fb low bits");
        chk(K_SRC, 0, "R7 src shadow before start");

        // R1 / R3: start SHA-256 with HMAC
        wr(A_CTRL, 32'h0000_0C01);
        chk(K_START, 1, "R1 start pulse"); chk(K_ALGO, 2, "R3 sha256");
        chk(K_HMAC, 1, "R3 hmac");
        chk(K_SRC, 32'h1000_0004, "R7 src latched"); chk(K_CNT, 64, "R7 cnt latched");
        chk(K_KCNT, 32, "R7 kcnt latched"); chk(K_FB, 32'h2000, "R8 fb latched");
        step();
        chk(K_START, 0, "R1 pulse one cycle");
        rd(A_CTRL, 32'h0000_0C00, "R1 start reads 0");
        rd(A_STAT, 32'h0000_0001, "R1 busy set");

        // R4 / R7: writes while busy
        wr(A_CTRL, 32'h0000_0600);
        chk(K_ALGO, 2, "R4 algo frozen"); chk(K_HMAC, 1, "R4 hmac frozen");
        rd(A_CTRL, 32'h0000_0600, "R4 ctrl stored");
        wr(A_SRC, 32'h0000_3000);
        wr(A_KCNT, 32'h0000_0099);
        chk(K_SRC, 32'h1000_0004, "R7 src held"); chk(K_KCNT, 32, "R7 kcnt held");
        rd(A_SRC, 32'h0000_3000, "R7 src live");
        wr(A_CTRL, 32'h0000_0601);
        chk(K_START, 0, "R4 start while busy ignored"); chk(K_ALGO, 2, "R4 algo kept");

        // R6: status fields and write immunity
        eng_dma_busy = 1'b1; eng_dma_err = 1'b1; eng_data_req = 1'b1;
        step();
        rd(A_STAT, 32'h0001_0103, "R6 status bits");
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, 32'h0001_0103, "R6 status write ignored");
        rd(A_CTRL, 32'h0000_0600, "R6 ctrl untouched");
        eng_dma_busy = 1'b0; eng_dma_err = 1'b0; eng_data_req = 1'b0;

        // R5: done and start in the same cycle, SHA-224
        eng_done = 1'b1;
        wr(A_CTRL, 32'h0000_0501);
        eng_done = 1'b0;
        chk(K_START, 1, "R5 restart pulse"); chk(K_ALGO, 1, "R5 sha224");
        chk(K_HMAC, 0, "R5 hmac off"); chk(K_SRC, 32'h3000, "R5 src new");
        chk(K_KCNT, 32'h99, "R5 kcnt new");
        rd(A_STAT, 32'h0000_0001, "R5 busy kept");
        eng_done = 1'b1;
        step();
        eng_done = 1'b0;
        rd(A_STAT, 0, "R5 done clears busy");

        // R10: key error in a plain SHA-384 run has no effect
        wr(A_CTRL, 32'h0000_0701);
        chk(K_ALGO, 3, "R3 sha384"); chk(K_START, 1, "R1 start pulse plain");
        eng_key_err = 1'b1;
        step();
        chk(K_STOP, 0, "R10 no abort plain");
        rd(A_STAT, 32'h0000_0201, "R10 busy kept plain");
        eng_key_err = 1'b0;

        // R2: stop and start written together
        wr(A_CTRL, 32'h0000_0703);
        chk(K_STOP, 1, "R2 stop pulse"); chk(K_START, 0, "R2 stop beats start");
        rd(A_STAT, 0, "R2 busy cleared");
        chk(K_STOP, 0, "R2 pulse one cycle");
        rd(A_CTRL, 32'h0000_0700, "R2 stop reads 0");

        // R10: key error in an HMAC SM3 run aborts
        wr(A_CTRL, 32'h0000_2801);
        chk(K_ALGO, 5, "R3 sm3 override"); chk(K_HMAC, 1, "R3 hmac sm3");
        eng_key_err = 1'b1;
        step();
        chk(K_STOP, 1, "R10 abort stop");
        rd(A_STAT, 32'h0000_0200, "R10 abort busy cleared");
        eng_key_err = 1'b0;

        // R3: mode 011 still gives SHA-1; 110 gives SHA-512
        wr(A_CTRL, 32'h0000_0301);
        chk(K_ALGO, 0, "R3 sha1 dont-care");
        wr(A_CTRL, 32'h0000_0002);
        chk(K_STOP, 1, "R2 stop sha1 run");
        wr(A_CTRL, 32'h0000_0601);
        chk(K_ALGO, 4, "R3 sha512");
        wr(A_CTRL, 32'h0000_0002);

        // R9: key selector fields and zero readback
        wr(A_KEY, 32'hFFFF_FFB5);
        chk(K_KEY, 32'h0000_00B5, "R9 key fields otp");
        rd(A_KEY, 0, "R9 key reads 0");
        wr(A_KEY, 32'h0000_002A);
        chk(K_KEY, 32'h0000_002A, "R9 key fields sram");
        rd(8'h3C, 0, "R6 unmapped reads 0");

        step();
        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule